// File: doc/BRIEF.md
# Center-Symmetric Six-Leg Three-Level PWM Sequencer

This block sets the level (0, 1 or 2) of each of six inverter legs over one switching period. The caller supplies three things: a starting level for each leg, the order in which the legs are to be stepped, and six dwell counts. In the rising half of the period the legs are lifted one level at a time in the given order, so seven distinct states are produced. The falling half then plays those states back in reverse, which gives a pattern that is symmetric about the middle of the period.

The first dwell count belongs to the vector formed by the opening state and the closing state. It is split between them: the opening state takes the lower half and the closing state takes the rest, including any odd cycle. The five other counts set how long each intermediate state is held. The full period is therefore twice the sum of the six counts.

An internal period counter times the pattern. The parameter inputs are read only on the cycle at which that counter wraps. A parameter set that breaks the rules is refused. In that case an error flag is raised and the previously accepted pattern is replayed from its start.

Top module: `sixleg_pwm_seq`

## Requirements
- R1: While `rst` is high and on the first output cycle after reset, every leg reads level 0, and `prd_start` and `seq_err` are low.
- R2: Leg i's level is carried in bits [2i+1:2i] of `start_lvl` and `leg_lvl`. Slot j of `step_order` (bits [3j+2:3j]) names the leg that rises at rising step j+1. The opening state equals `start_lvl`, and each later state raises one more leg by one level.
- R3: Dwell j sits in bits [8j+7:8j] of `dwell`. In the rising half, the opening state lasts floor(T0/2) cycles, the state after step j lasts Tj cycles (j = 1 to 5), and the state after step 6 lasts T0 - floor(T0/2) cycles.
- R4: The falling half holds the same states in reverse order, each for the same duration, so one period lasts 2*(T0+...+T5) cycles.
- R5: `prd_start` is high for exactly the first cycle of each period, and on that cycle the legs show the opening state.
- R6: A parameter set whose starting level on any leg is 2 or more is refused.
- R7: A parameter set whose `step_order` does not name each of the six legs exactly once is refused, since a leg would rise twice or not at all.
- R8: A parameter set with T0 below 2 or any other dwell equal to 0 is refused.
- R9: `seq_err` is updated at each period boundary: it goes high when the set is refused and low when it is accepted. After a refusal, the previously accepted pattern restarts from its first cycle.
- R10: Changes on `start_lvl`, `step_order` or `dwell` during a period have no effect until the next period boundary.
- R11: Within a period, two consecutive cycles differ in at most one leg, and by at most one level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_lvl | input | 2*NLEG | Starting level of each leg |
| step_order | input | LW*NLEG | Leg index for each rising step |
| dwell | input | DW*NLEG | Dwell count for each vector, in clock cycles |
| leg_lvl | output | 2*NLEG | Registered level of each leg |
| prd_start | output | 1 | High on the first cycle of each period |
| seq_err | output | 1 | The most recent boundary refused its parameters |

## Verification
The assertions for single-step movement and for the period start rest on the fact that every accepted set has positive dwells and starting levels of 0 or 1. Under that condition no state is skipped, and the opening state is always visible. The validation logic makes this hold for any input. Even so, the stimulus feeds the rules through refused sets only, and it changes inputs partway through a period only to show that such changes are ignored. The bench model rebuilds the expected pattern from the requirements as a per-cycle queue and compares it with the outputs on every cycle.

// File: rtl/seq6_pkg.sv
package seq6_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_HI_START = 2'd1;
endpackage

// File: rtl/seq6_param_chk.sv
module seq6_param_chk
  import seq6_pkg::*;
#(
  parameter int NLEG = 6,
  parameter int DW   = 8,
  parameter int LW   = 3,
  parameter int SW   = 11
) (
  input  logic [LVL_W*NLEG-1:0] start_i,
  input  logic [LW*NLEG-1:0]    order_i,
  input  logic [DW*NLEG-1:0]    dwell_i,
  output logic                  ok_o,
  output logic [SW*NLEG-1:0]    bnd_o,
  output logic [SW-1:0]         half_o
);
  logic [NLEG-1:0] start_ok, perm_ok, dw_ok;
  logic [SW-1:0]   acc [NLEG];
  logic [DW-1:0]   t0;

  assign t0 = dwell_i[DW-1:0];

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    int hits;
    assign start_ok[g] = lvl_t'(start_i[g*LVL_W +: LVL_W]) <= LVL_HI_START;
    always_comb begin
      hits = 0;
      for (int i = 0; i < NLEG; i++)
        if (order_i[i*LW +: LW] == LW'(g)) hits = hits + 1;
    end
    assign perm_ok[g] = (hits == 1);
    if (g == 0) begin : g_first
      assign dw_ok[g] = (t0 >= DW'(2));
      assign acc[g]   = SW'(t0 >> 1);
    end else begin : g_rest
      assign dw_ok[g] = (dwell_i[g*DW +: DW] != '0);
      assign acc[g]   = acc[g-1] + SW'(dwell_i[g*DW +: DW]);
    end
    assign bnd_o[g*SW +: SW] = acc[g];
  end

  assign half_o = acc[NLEG-1] + SW'(t0 - (t0 >> 1));
  assign ok_o   = (&start_ok) & (&perm_ok) & (&dw_ok);
endmodule

// File: rtl/seq6_step_loc.sv
module seq6_step_loc #(
  parameter int NLEG = 6,
  parameter int SW   = 11,
  parameter int PW   = 12,
  parameter int KW   = 3
) (
  input  logic [PW-1:0]      pos_i,
  input  logic [PW-1:0]      plen_i,
  input  logic [SW-1:0]      half_i,
  input  logic [SW*NLEG-1:0] bnd_i,
  output logic [KW-1:0]      k_o
);
  logic [PW-1:0] fold;

  // fold the falling half onto the rising half
  assign fold = (pos_i < {1'b0, half_i}) ? pos_i : (plen_i - PW'(1) - pos_i);

  always_comb begin
    k_o = '0;
    for (int i = 0; i < NLEG; i++)
      if (fold >= {1'b0, bnd_i[i*SW +: SW]}) k_o = k_o + KW'(1);
  end
endmodule

// File: rtl/seq6_lvl_build.sv
module seq6_lvl_build
  import seq6_pkg::*;
#(
  parameter int NLEG = 6,
  parameter int LW   = 3,
  parameter int KW   = 3
) (
  input  logic [LVL_W*NLEG-1:0] start_i,
  input  logic [LW*NLEG-1:0]    order_i,
  input  logic [KW-1:0]         k_i,
  output logic [LVL_W*NLEG-1:0] lvl_o
);
  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic raised;
    always_comb begin
      raised = 1'b0;
      for (int i = 0; i < NLEG; i++)
        if ((KW'(i) < k_i) && (order_i[i*LW +: LW] == LW'(g))) raised = 1'b1;
    end
    assign lvl_o[g*LVL_W +: LVL_W] = start_i[g*LVL_W +: LVL_W] + {1'b0, raised};
  end
endmodule

// File: rtl/sixleg_pwm_seq.sv
module sixleg_pwm_seq
  import seq6_pkg::*;
#(
  parameter  int NLEG = 6,
  parameter  int DW   = 8,
  localparam int LW   = $clog2(NLEG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LVL_W*NLEG-1:0] start_lvl,
  input  logic [LW*NLEG-1:0]    step_order,
  input  logic [DW*NLEG-1:0]    dwell,
  output logic [LVL_W*NLEG-1:0] leg_lvl,
  output logic                  prd_start,
  output logic                  seq_err
);
  localparam int SW = DW + $clog2(NLEG);
  localparam int PW = SW + 1;
  localparam int KW = $clog2(NLEG + 1);

  logic [PW-1:0]         cnt_q, plen_q, nxt_cnt, sel_plen;
  logic [SW-1:0]         half_q, sel_half, chk_half;
  logic [SW*NLEG-1:0]    bnd_q, sel_bnd, chk_bnd;
  logic [LVL_W*NLEG-1:0] start_q, sel_start, nxt_lvl;
  logic [LW*NLEG-1:0]    order_q, sel_order;
  logic [KW-1:0]         nxt_k;
  logic                  chk_ok, wrap, take;

  seq6_param_chk #(.NLEG(NLEG), .DW(DW), .LW(LW), .SW(SW)) u_pchk (
    .start_i(start_lvl), .order_i(step_order), .dwell_i(dwell),
    .ok_o(chk_ok), .bnd_o(chk_bnd), .half_o(chk_half)
  );

  assign wrap      = (cnt_q == plen_q - PW'(1));
  assign take      = wrap & chk_ok;
  assign nxt_cnt   = wrap ? '0 : cnt_q + PW'(1);
  assign sel_plen  = take ? {chk_half, 1'b0} : plen_q;
  assign sel_half  = take ? chk_half   : half_q;
  assign sel_bnd   = take ? chk_bnd    : bnd_q;
  assign sel_start = take ? start_lvl  : start_q;
  assign sel_order = take ? step_order : order_q;

  seq6_step_loc #(.NLEG(NLEG), .SW(SW), .PW(PW), .KW(KW)) u_loc (
    .pos_i(nxt_cnt), .plen_i(sel_plen), .half_i(sel_half), .bnd_i(sel_bnd), .k_o(nxt_k)
  );

  seq6_lvl_build #(.NLEG(NLEG), .LW(LW), .KW(KW)) u_bld (
    .start_i(sel_start), .order_i(sel_order), .k_i(nxt_k), .lvl_o(nxt_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      plen_q    <= PW'(1);
      half_q    <= '0;
      bnd_q     <= '1;
      start_q   <= '0;
      order_q   <= '0;
      leg_lvl   <= '0;
      prd_start <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      cnt_q     <= nxt_cnt;
      leg_lvl   <= nxt_lvl;
      prd_start <= wrap;
      if (wrap) seq_err <= ~chk_ok;
      if (take) begin
        plen_q  <= sel_plen;
        half_q  <= chk_half;
        bnd_q   <= chk_bnd;
        start_q <= start_lvl;
        order_q <= step_order;
      end
    end
  end
endmodule

// File: rtl/seq6_pwm_chk.sv
module seq6_pwm_chk #(
  parameter int NLEG = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [2*NLEG-1:0] lvl,
  input logic              prd,
  input logic              err,
  input logic              wrap
);
  function automatic logic one_step(input logic [2*NLEG-1:0] a, input logic [2*NLEG-1:0] b);
    int moved;
    int da, db;
    moved = 0;
    for (int l = 0; l < NLEG; l++) begin
      da = int'(a[2*l +: 2]);
      db = int'(b[2*l +: 2]);
      if (da != db) moved = moved + 1;
      if (da - db > 1 || db - da > 1) return 1'b0;
    end
    return moved <= 1;
  endfunction

  function automatic logic all_below(input logic [2*NLEG-1:0] a, input int lim);
    for (int l = 0; l < NLEG; l++)
      if (int'(a[2*l +: 2]) > lim) return 1'b0;
    return 1'b1;
  endfunction

  // R11
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    !prd |-> one_step(lvl, $past(lvl)));

  // R2
  lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
    all_below(lvl, 2));

  // R5
  open_state_chk: assert property (@(posedge clk) disable iff (rst)
    prd |-> all_below(lvl, 1));

  // R5
  prd_align_chk: assert property (@(posedge clk) disable iff (rst)
    prd |-> $past(wrap));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(err));
endmodule

bind sixleg_pwm_seq seq6_pwm_chk #(.NLEG(NLEG)) u_pwm_chk (
  .clk(clk), .rst(rst), .lvl(leg_lvl), .prd(prd_start), .err(seq_err), .wrap(wrap)
);

// File: tb/sixleg_pwm_seq_bench.sv
module sixleg_pwm_seq_bench;
  localparam int NLEG = 6;
  localparam int DW   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] start_lvl = '0;
  logic [17:0] step_order = '0;
  logic [47:0] dwell = '0;
  logic [11:0] leg_lvl;
  logic        prd_start, seq_err;

  sixleg_pwm_seq #(.NLEG(NLEG), .DW(DW)) u_sixleg_pwm_seq (
    .clk(clk), .rst(rst), .start_lvl(start_lvl), .step_order(step_order),
    .dwell(dwell), .leg_lvl(leg_lvl), .prd_start(prd_start), .seq_err(seq_err)
  );

  always #4 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    armed = 0;
  bit    done = 0;

  // behavioural reference: one queue entry per cycle of the accepted period
  logic [11:0] pat[$];
  int          idx;
  logic [11:0] exp_lvl = '0;
  bit          exp_ps = 0, exp_err = 0;

  function automatic bit params_ok(input logic [11:0] s, input logic [17:0] o, input logic [47:0] d);
    int seen[6];
    for (int l = 0; l < 6; l++) seen[l] = 0;
    for (int l = 0; l < 6; l++) if (s[2*l +: 2] > 2'd1) return 0;
    for (int j = 0; j < 6; j++) begin
      if (o[3*j +: 3] > 3'd5) return 0;
      seen[o[3*j +: 3]]++;
    end
    for (int l = 0; l < 6; l++) if (seen[l] != 1) return 0;
    if (d[7:0] < 8'd2) return 0;
    for (int j = 1; j < 6; j++) if (d[8*j +: 8] == 8'd0) return 0;
    return 1;
  endfunction

  task automatic build_pat(input logic [11:0] s, input logic [17:0] o, input logic [47:0] d);
    logic [11:0] st[7];
    int dur[7];
    st[0] = s;
    for (int j = 1; j < 7; j++) begin
      st[j] = st[j-1];
      st[j][2*o[3*(j-1) +: 3] +: 2] = st[j-1][2*o[3*(j-1) +: 3] +: 2] + 2'd1;
    end
    dur[0] = int'(d[7:0]) / 2;
    for (int j = 1; j < 6; j++) dur[j] = int'(d[8*j +: 8]);
    dur[6] = int'(d[7:0]) - dur[0];
    pat = {};
    for (int j = 0; j < 7; j++) repeat (dur[j]) pat.push_back(st[j]);
    for (int j = 6; j >= 0; j--) repeat (dur[j]) pat.push_back(st[j]);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      pat = {12'd0};
      idx = 1;
      exp_lvl = '0; exp_ps = 0; exp_err = 0;
      armed = 1;
    end else begin
      if (idx >= pat.size()) begin
        if (params_ok(start_lvl, step_order, dwell)) begin
          build_pat(start_lvl, step_order, dwell);
          exp_err = 0;
        end else begin
          exp_err = 1;
        end
        idx = 0;
        exp_ps = 1;
      end else begin
        exp_ps = 0;
      end
      exp_lvl = pat[idx];
      idx++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  logic [11:0] prev_lvl = '0;
  always @(negedge clk) begin
    if (armed && !done) begin
      check(tag, "leg_lvl", int'(leg_lvl), int'(exp_lvl));
      check("R5", "prd_start", int'(prd_start), int'(exp_ps));
      check("R9", "seq_err", int'(seq_err), int'(exp_err));
      if (!rst && !prd_start) begin
        int moved = 0;
        bit big = 0;
        for (int l = 0; l < 6; l++) begin
          int a = int'(leg_lvl[2*l +: 2]);
          int b = int'(prev_lvl[2*l +: 2]);
          if (a != b) moved++;
          if (a - b > 1 || b - a > 1) big = 1;
        end
        check("R11", "single-step move", int'(moved <= 1 && !big), 1);
      end
      prev_lvl = leg_lvl;
    end
  end

  task automatic apply(input logic [11:0] s, input logic [17:0] o, input logic [47:0] d);
    start_lvl = s; step_order = o; dwell = d;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset leg_lvl", int'(leg_lvl), 0);
    check("R1", "reset seq_err", int'(seq_err), 0);
    // R2: sequence 110001 -> ... -> 221112, odd T0
    apply({2'd1,2'd0,2'd0,2'd0,2'd1,2'd1},
          {3'd5,3'd3,3'd4,3'd1,3'd0,3'd2},
          {8'd6,8'd1,8'd4,8'd2,8'd3,8'd5});
    tag = "R1";
    rst = 1'b0;
    @(negedge clk);
    tag = "R2";
    repeat (100) @(negedge clk);
    // R3: even T0, other order
    tag = "R3";
    apply({2'd0,2'd1,2'd0,2'd1,2'd0,2'd0},
          {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5},
          {8'd1,8'd2,8'd1,8'd3,8'd2,8'd4});
    repeat (80) @(negedge clk);
    // R4: all-zero start, reverse order, minimum dwells
    tag = "R4";
    apply(12'd0, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5},
          {8'd1,8'd1,8'd1,8'd1,8'd1,8'd2});
    repeat (60) @(negedge clk);
    // R6: starting level of 2 refused
    tag = "R6";
    apply({2'd0,2'd0,2'd2,2'd0,2'd0,2'd1},
          {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},
          {8'd3,8'd3,8'd3,8'd3,8'd3,8'd3});
    repeat (50) @(negedge clk);
    // R7: duplicated leg in order refused
    tag = "R7";
    apply(12'd0, {3'd5,3'd4,3'd3,3'd2,3'd1,3'd1},
          {8'd3,8'd3,8'd3,8'd3,8'd3,8'd3});
    repeat (50) @(negedge clk);
    // R8: T0 of 1 refused, then a zero middle dwell
    tag = "R8";
    apply(12'd0, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5},
          {8'd3,8'd3,8'd3,8'd3,8'd3,8'd1});
    repeat (40) @(negedge clk);
    apply(12'd0, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5},
          {8'd3,8'd3,8'd0,8'd3,8'd3,8'd4});
    repeat (40) @(negedge clk);
    // R9: accepted set clears the flag
    tag = "R9";
    apply({2'd1,2'd1,2'd1,2'd1,2'd1,2'd1},
          {3'd2,3'd4,3'd0,3'd5,3'd1,3'd3},
          {8'd2,8'd2,8'd2,8'd2,8'd2,8'd3});
    repeat (60) @(negedge clk);
    // R10: inputs toggled mid-period are ignored until the boundary
    tag = "R10";
    apply(12'd0, {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},
          {8'd5,8'd5,8'd5,8'd5,8'd5,8'd6});
    repeat (5) @(negedge clk);
    for (int r = 0; r < 12; r++) begin
      apply((r % 2) ? 12'd0 : 12'b010101010101,
            (r % 2) ? {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0} : {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5},
            {8'd5,8'd5,8'd5,8'd5,8'd5,8'd6});
      repeat (7 + r) @(negedge clk);
    end
    repeat (80) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule